// File: doc/BRIEF.md
# CAN Receive Message Buffer Frontend

This block sits between a CAN receiver and the processor's register bus. Frames that have already been received and filtered enter through a one-cycle push port and are queued in a small first-in first-out store. Software reads the oldest frame through four fixed register offsets: identifier, length code, first data word and second data word. Reading the second data word removes the frame, so a complete read always goes in the order identifier, length, word 1, word 2. A remote frame carries no data, but both data words must still be read to remove it.

Three interrupt events are kept in a status register: a frame was accepted, a frame was lost because the store was full, and the store holds at least one frame. An enable register selects which events raise the single interrupt line. A clear register removes status bits by writing ones. A flush input empties the store in one cycle. It is meant to be pulsed after an overflow has been handled.

Top module: `canrx_buf_front`

## Requirements
- R1: After synchronous active-low reset the status and enable registers read 0, `irq` is low and the store is empty.
- R2: A read (`reg_rd` high) returns its value on `reg_rdata` one cycle later. For the oldest frame, offset 0x50 returns the identifier, 0x54 returns the length code in bits 31:28 with all other bits 0, 0x58 returns data word 1 and 0x5C returns data word 2.
- R3: A frame is removed only by a read of 0x5C while the store is not empty. Reads of 0x50, 0x54 and 0x58 remove nothing. Frames come out in arrival order.
- R4: While the store is empty, reads of 0x50, 0x54, 0x58 and 0x5C return 0 and change nothing.
- R5: Status bit 4 (offset 0x1C) is set in the cycle after each push that is accepted.
- R6: A push into a full store is dropped, except when the same cycle also removes a frame. A dropped push leaves the stored frames unchanged and sets status bit 6.
- R7: Status bit 7 is set on every clock edge at which the store holds at least one frame. A clear therefore has no lasting effect while frames remain.
- R8: Writing offset 0x24 clears each status bit whose write-data bit is 1 and leaves the others unchanged. If a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The enable register at 0x20 keeps only bits 7, 6 and 4 of the written data and reads back the same bits. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: A `fifo_flush` pulse empties the store at the next edge. A push in the same cycle is dropped without setting any status bit. Status bits are not touched by the flush.
- R11: Writes to offset 0x1C and reads of 0x24 or any unmapped offset have no effect; those reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | One-cycle push of a received frame |
| rx_id | input | 32 | Identifier word of the pushed frame |
| rx_len | input | 4 | Length code of the pushed frame |
| rx_dw1 | input | 32 | Data word 1 of the pushed frame |
| rx_dw2 | input | 32 | Data word 2 of the pushed frame |
| fifo_flush | input | 1 | Empties the store |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences first cover the cases that random traffic rarely reaches. Partial frame reads show whether removal is tied only to the last word. Filling past capacity separates dropped pushes from a push that coincides with a removal. A clear while frames remain shows that the not-empty bit comes back, and a push together with a clear of the same bit shows the set-wins rule. A flush together with a push shows the flush priority. A seeded random mix of pushes, reads at every offset, enable and clear writes and rare flushes then runs the store through empty, partly full and full states. Every read value and the interrupt line are compared each cycle with a bench model built from the requirements.

// File: rtl/canrx_pkg.sv
// Shared types and constants for the CAN receive buffer frontend.
// Assumes 32-bit register words and byte offsets that fit in 8 bits.
package canrx_pkg;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  len;
        logic [31:0] dw1;
        logic [31:0] dw2;
    } rx_frame_t;

    localparam logic [7:0] OFF_STATUS = 8'h1C;
    localparam logic [7:0] OFF_ENABLE = 8'h20;
    localparam logic [7:0] OFF_CLEAR  = 8'h24;
    localparam logic [7:0] OFF_ID     = 8'h50;
    localparam logic [7:0] OFF_LEN    = 8'h54;
    localparam logic [7:0] OFF_DW1    = 8'h58;
    localparam logic [7:0] OFF_DW2    = 8'h5C;

    localparam int RXOK_BIT = 4;
    localparam int OVF_BIT  = 6;
    localparam int NE_BIT   = 7;
    localparam int LEN_LSB  = 28;

endpackage

// File: rtl/canrx_fifo.sv
// Frame store: a circular buffer of DEPTH frames.
// Assumes push and pop are single-cycle strobes. Flush has priority over both.
// A push into a full store is accepted only if the same cycle pops.
module canrx_fifo
    import canrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush_i,
    input  logic      push_i,
    input  rx_frame_t push_data_i,
    input  logic      pop_i,
    output rx_frame_t head_o,
    output logic      empty_o,
    output logic      push_ok_o,
    output logic      push_drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_frame_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Status flags and the accept/drop decision for this cycle.
    always_comb begin
        empty_o     = (cnt == '0);
        full        = (cnt == CNT_W'(DEPTH));
        do_pop      = pop_i && !empty_o && !flush_i;
        push_ok_o   = push_i && !flush_i && (!full || do_pop);
        push_drop_o = push_i && !flush_i && !push_ok_o;
    end

    // Frame storage; needs no reset because the count masks stale slots.
    always_ff @(posedge clk) begin
        if (push_ok_o) begin
            mem[wr_ptr] <= push_data_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok_o) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)    rd_ptr <= ptr_inc(rd_ptr);
            cnt <= cnt + CNT_W'(push_ok_o) - CNT_W'(do_pop);
        end
    end

    assign head_o = mem[rd_ptr];

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    p_pop_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !do_pop && push_ok_o) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/canrx_irq_regs.sv
// Interrupt status and enable registers for three events.
// Each status bit is sticky and cleared by writing 1 to it; a set event beats
// a clear in the same cycle. Enable keeps only the implemented bit positions.
module canrx_irq_regs
    import canrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_rxok_i,
    input  logic        ev_ovf_i,
    input  logic        ev_ne_i,
    input  logic        en_we_i,
    input  logic        clr_we_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] status_o,
    output logic [31:0] enable_o,
    output logic        irq_o
);
    localparam int NEV = 3;
    localparam int POS [NEV] = '{RXOK_BIT, OVF_BIT, NE_BIT};

    logic [NEV-1:0] ev;
    logic [NEV-1:0] st_vec;
    logic [NEV-1:0] en_vec;

    assign ev = {ev_ne_i, ev_ovf_i, ev_rxok_i};

    for (genvar g = 0; g < NEV; g++) begin : g_bit
        logic st_q;
        logic en_q;

        // Sticky status bit: set wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= 1'b0;
            else        st_q <= ev[g] | (st_q & ~(clr_we_i & wdata_i[POS[g]]));
        end

        // Enable bit: loaded from the matching write-data bit.
        always_ff @(posedge clk) begin
            if (!rst_n)       en_q <= 1'b0;
            else if (en_we_i) en_q <= wdata_i[POS[g]];
        end

        assign st_vec[g] = st_q;
        assign en_vec[g] = en_q;
    end

    // Place the implemented bits at their register positions.
    always_comb begin
        status_o = '0;
        enable_o = '0;
        for (int i = 0; i < NEV; i++) begin
            status_o[POS[i]] = st_vec[i];
            enable_o[POS[i]] = en_vec[i];
        end
    end

    assign irq_o = |(st_vec & en_vec);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxok_i |=> status_o[RXOK_BIT]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && wdata_i[RXOK_BIT] && !ev_rxok_i) |=> !status_o[RXOK_BIT]);

    p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf_i |=> status_o[OVF_BIT]);

    p_ne_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ne_i |=> status_o[NE_BIT]);

endmodule

// File: rtl/canrx_rd_mux.sv
// Read-data selection for all register offsets.
// Frame offsets return 0 while the store is empty; unmapped offsets return 0.
module canrx_rd_mux
    import canrx_pkg::*;
(
    input  logic [7:0]  addr_i,
    input  rx_frame_t   head_i,
    input  logic        empty_i,
    input  logic [31:0] status_i,
    input  logic [31:0] enable_i,
    output logic [31:0] data_o
);
    // Decode the offset into the value software sees.
    always_comb begin
        data_o = '0;
        case (addr_i)
            OFF_STATUS: data_o = status_i;
            OFF_ENABLE: data_o = enable_i;
            OFF_ID:     if (!empty_i) data_o = head_i.id;
            OFF_LEN:    if (!empty_i) data_o = {head_i.len, {LEN_LSB{1'b0}}};
            OFF_DW1:    if (!empty_i) data_o = head_i.dw1;
            OFF_DW2:    if (!empty_i) data_o = head_i.dw2;
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/canrx_buf_front.sv
// Top level of the CAN receive buffer frontend.
// Decodes register strobes, removes the head frame on a read of the last data
// word, and registers read data for one-cycle read latency.
module canrx_buf_front
    import canrx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_push,
    input  logic [31:0] rx_id,
    input  logic [3:0]  rx_len,
    input  logic [31:0] rx_dw1,
    input  logic [31:0] rx_dw2,
    input  logic        fifo_flush,
    input  logic [7:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    rx_frame_t   push_frame;
    rx_frame_t   head;
    logic        empty;
    logic        push_ok;
    logic        push_drop;
    logic        pop_req;
    logic        en_we;
    logic        clr_we;
    logic [31:0] status;
    logic [31:0] enable;
    logic [31:0] rd_value;

    // Bundle the push fields and decode the register strobes.
    always_comb begin
        push_frame = '{id: rx_id, len: rx_len, dw1: rx_dw1, dw2: rx_dw2};
        pop_req    = reg_rd && (reg_addr == OFF_DW2);
        en_we      = reg_wr && (reg_addr == OFF_ENABLE);
        clr_we     = reg_wr && (reg_addr == OFF_CLEAR);
    end

    canrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (fifo_flush),
        .push_i      (rx_push),
        .push_data_i (push_frame),
        .pop_i       (pop_req),
        .head_o      (head),
        .empty_o     (empty),
        .push_ok_o   (push_ok),
        .push_drop_o (push_drop)
    );

    canrx_irq_regs u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_rxok_i (push_ok),
        .ev_ovf_i  (push_drop),
        .ev_ne_i   (!empty),
        .en_we_i   (en_we),
        .clr_we_i  (clr_we),
        .wdata_i   (reg_wdata),
        .status_o  (status),
        .enable_o  (enable),
        .irq_o     (irq)
    );

    canrx_rd_mux u_mux (
        .addr_i   (reg_addr),
        .head_i   (head),
        .empty_i  (empty),
        .status_i (status),
        .enable_i (enable),
        .data_o   (rd_value)
    );

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_value;
    end

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && pop_req && empty) |=> (reg_rdata == 32'h0));

    p_status_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STATUS && !rx_push && !push_ok && empty
         && !status[NE_BIT]) |=> (status[NE_BIT] == 1'b0));

endmodule

// File: tb/canrx_buf_front_test.sv
`timescale 1ns/1ps
module canrx_buf_front_test;
    localparam int DEPTH = 8;
    localparam logic [31:0] MASK = 32'h0000_00D0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 1'b0;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_len = '0;
    logic [31:0] rx_dw1 = '0;
    logic [31:0] rx_dw2 = '0;
    logic        fifo_flush = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_id  [DEPTH];
    logic [3:0]  m_len [DEPTH];
    logic [31:0] m_d1  [DEPTH];
    logic [31:0] m_d2  [DEPTH];
    int          m_cnt = 0;
    logic [31:0] m_st  = '0;
    logic [31:0] m_en  = '0;
    string       tag   = "";

    canrx_buf_front #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_id(rx_id),
        .rx_len(rx_len), .rx_dw1(rx_dw1), .rx_dw2(rx_dw2),
        .fifo_flush(fifo_flush), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C: return m_st;
            8'h20: return m_en;
            8'h50: return (m_cnt != 0) ? m_id[0] : 32'h0;
            8'h54: return (m_cnt != 0) ? {m_len[0], 28'h0} : 32'h0;
            8'h58: return (m_cnt != 0) ? m_d1[0] : 32'h0;
            8'h5C: return (m_cnt != 0) ? m_d2[0] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a, input int cnt);
        if (a == 8'h50 || a == 8'h54 || a == 8'h58) return (cnt != 0) ? "R2" : "R4";
        if (a == 8'h5C) return (cnt != 0) ? "R3" : "R4";
        if (a == 8'h1C) return "R5/R6/R7/R8";
        if (a == 8'h20) return "R9";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the inputs currently driven; the model advances alongside.
    task automatic step();
        logic [31:0] exp_rd;
        logic [31:0] clr;
        logic [31:0] setv;
        bit pop, acc, drop;
        string rtag;
        exp_rd = model_read(reg_addr);
        rtag   = (tag != "") ? tag : addr_tag(reg_addr, m_cnt);
        pop    = reg_rd && reg_addr == 8'h5C && m_cnt != 0 && !fifo_flush;
        acc    = rx_push && !fifo_flush && (m_cnt < DEPTH || pop);
        drop   = rx_push && !fifo_flush && !acc;
        setv   = (acc ? 32'h10 : 32'h0) | (drop ? 32'h40 : 32'h0) | ((m_cnt != 0) ? 32'h80 : 32'h0);
        clr    = (reg_wr && reg_addr == 8'h24) ? reg_wdata : 32'h0;
        @(posedge clk);
        #1;
        m_st = ((m_st & ~clr) | setv) & MASK;
        if (reg_wr && reg_addr == 8'h20) m_en = reg_wdata & MASK;
        if (fifo_flush) m_cnt = 0;
        else begin
            if (pop) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    m_id[i] = m_id[i+1]; m_len[i] = m_len[i+1];
                    m_d1[i] = m_d1[i+1]; m_d2[i] = m_d2[i+1];
                end
                m_cnt--;
            end
            if (acc) begin
                m_id[m_cnt] = rx_id; m_len[m_cnt] = rx_len;
                m_d1[m_cnt] = rx_dw1; m_d2[m_cnt] = rx_dw2;
                m_cnt++;
            end
        end
        if (reg_rd) check(rtag, reg_rdata, exp_rd);
        check("R9 irq", {31'h0, irq}, {31'h0, |(m_st & m_en)});
        rx_push = 0; reg_rd = 0; reg_wr = 0; fifo_flush = 0;
    endtask

    task automatic set_push(input int n);
        rx_push = 1;
        rx_id   = $urandom;
        rx_len  = 4'(n);
        rx_dw1  = $urandom;
        rx_dw2  = $urandom;
    endtask

    task automatic do_read(input logic [7:0] a);
        reg_rd = 1; reg_addr = a; step();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; step();
    endtask

    task automatic do_push(input int n);
        set_push(n); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C4A));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;

        // R1: reset state
        tag = "R1";
        do_read(8'h1C); do_read(8'h20); do_read(8'h50);
        check("R1 irq", {31'h0, irq}, 32'h0);
        tag = "";

        // R2 / R3: partial reads keep the frame, last word removes it in order
        do_push(3); do_push(8); do_push(0);
        do_read(8'h50); do_read(8'h54); do_read(8'h58);
        do_read(8'h50); do_read(8'h54); do_read(8'h58);
        do_read(8'h5C); do_read(8'h50); do_read(8'h5C); do_read(8'h5C);

        // R4: empty reads return zero
        do_read(8'h5C); do_read(8'h50); do_read(8'h58);

        // R9: enable mask and interrupt line
        do_write(8'h20, 32'hFFFF_FFFF); do_read(8'h20);

        // R6: overflow when full
        for (int i = 0; i < DEPTH + 2; i++) do_push(i);
        do_read(8'h1C);
        set_push(5); reg_rd = 1; reg_addr = 8'h5C; step();   // push with pop while full
        do_read(8'h50);

        // R7: clear of not-empty does not stick while frames remain
        do_write(8'h24, 32'h80); do_read(8'h1C);
        for (int i = 0; i < DEPTH; i++) do_read(8'h5C);
        step();
        do_write(8'h24, 32'hFF); do_read(8'h1C);

        // R8: set wins over clear in the same cycle
        set_push(2); reg_wr = 1; reg_addr = 8'h24; reg_wdata = 32'h10; step();
        do_read(8'h1C);

        // R11: status is read-only, clear offset reads zero
        do_write(8'h1C, 32'h0); do_read(8'h1C); do_read(8'h24); do_read(8'h7C);

        // R10: flush with a simultaneous push
        do_write(8'h24, 32'hFF);
        set_push(1); fifo_flush = 1; step();
        do_read(8'h1C); do_read(8'h5C);

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom_range(99));
            if (r < 40) set_push(int'($urandom_range(8)));
            r = int'($urandom_range(99));
            if (r < 45) begin
                logic [7:0] addrs [7] = '{8'h50, 8'h54, 8'h58, 8'h5C, 8'h5C, 8'h1C, 8'h20};
                reg_rd = 1; reg_addr = addrs[$urandom_range(6)];
            end else if (r < 55) begin
                reg_wr = 1;
                reg_addr = ($urandom_range(2) == 0) ? 8'h20 : (($urandom_range(1) == 0) ? 8'h24 : 8'h1C);
                reg_wdata = $urandom;
            end
            if ($urandom_range(199) == 0) fifo_flush = 1;
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule